// File: doc/BRIEF.md
# Dual Vector Pipe Issue Arbiter

This block sits at the issue point of a vector and floating-point cluster that has two execution pipes, called VS1 and VS2. Every cycle up to two candidate operations arrive. Slot 0 holds the older one and slot 1 the younger one. Each candidate carries a class code. In the same cycle the arbiter decides which candidates issue and to which pipe. A candidate that is not granted is reported as stalled, and the requester presents it again on a later cycle in the same slot order.

Three kinds of rule shape the grants:

- **Pipe affinity.** Vector integer work may run only on VS1. Permute and store-data work may run only on VS2. Floating-point work may run on either pipe.
- **Same-cycle cross-pipe block.** When an op with four single-precision inputs issues on VS1, no floating-point op may issue on VS2 in that cycle.
- **Write-back collision.** Vector integer and vector floating-point results share the VS1 write-back port, and their latencies differ. A vector integer op therefore must not issue on VS1 exactly `WB_GAP` cycles after a vector floating-point op issued there.

The arbiter tracks this last rule with a short history of VS1 vector floating-point issues. The grant decision is combinational in the same cycle as the request. Only the history is registered. Reset is asynchronous and active low, and its release is synchronized with two flops inside the block.

Class codes: 0 = vector integer (XS), 1 = permute / store data (PERM), 2 = scalar FP (SFP), 3 = vector FP, compare or round (VFP), 4 = four-single-input vector FP (QUAD). Codes 5 to 7 are not defined. Slot k's class is `req_cls_i[3k+2:3k]`. In `gnt_pipe_o`, bit k is 0 when slot k issues to VS1 and 1 when it issues to VS2.

Top module: `vs_issue_arb`

## Requirements
- R1: A class-0 (XS) op is granted only on VS1 (its `gnt_pipe_o` bit is 0).
- R2: A class-1 (PERM) op is granted only on VS2 (its `gnt_pipe_o` bit is 1).
- R3: Classes 2, 3 and 4 may use either pipe. A lone such op with nothing blocking it is granted on VS1.
- R4: Each pipe takes at most one op per cycle. When a legal pairing of both valid candidates exists, both issue. If both pairings are legal, the older op takes VS1. Otherwise the ops take the swapped assignment.
- R5: When a class-4 op is granted on VS1, no op of class 2, 3 or 4 is granted on VS2 in the same cycle. A permute on VS2 is still allowed.
- R6: A class-0 op is not granted on VS1 in the cycle exactly `WB_GAP` (default 5) cycles after a class-3 or class-4 op was granted on VS1. It is granted at distances 4 and 6. A class-2 op on VS1, or any op on VS2, does not arm this block.
- R7: When only one candidate can issue and both could alone, the older one (slot 0) wins. When the older one cannot issue at all, the younger one may take any free legal pipe.
- R8: `stall_o[k]` equals `req_vld_i[k]` and not `gnt_o[k]`. No grant is given without a valid request, and a `gnt_pipe_o` bit is 0 when its slot is not granted.
- R9: A request with an undefined class code (5 to 7) is never granted and is reported as stalled.
- R10: Reset clears the write-back history. After reset, a class-0 op on VS1 is not blocked by an issue made before reset, and with no requests all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld_i | input | 2 | Candidate valid, bit 0 = older slot |
| req_cls_i | input | 6 | Class code per slot, 3 bits each |
| gnt_o | output | 2 | Slot issued this cycle |
| gnt_pipe_o | output | 2 | Pipe of each granted slot: 0 = VS1, 1 = VS2 |
| stall_o | output | 2 | Valid slot not issued this cycle |

## Verification
The bench checks the collision window at distances 4, 5 and 6 after a VS1 vector FP issue. A history tap that is off by one cycle would grant at 5 or block at 4 or 6. It also checks that scalar FP on VS1 and vector FP on VS2 leave the window unarmed; a design that arms on any FP issue would block vector integer ops for no reason. It drives pairs that only fit in the swapped assignment, and two four-single-input ops together. A greedy older-to-VS1 policy would then stall a younger op that could issue, and a missing cross-pipe block would issue two FP ops against the rule. A reset pulse in the middle of an armed window must clear the history; if it does not, a vector integer op is wrongly stalled after reset.

// File: rtl/vsarb_pkg.sv
package vsarb_pkg;

  localparam int CLS_W      = 3;
  localparam int NSLOT      = 2;
  localparam int SYNC_DEPTH = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_XS   = 3'd0,
    CLS_PERM = 3'd1,
    CLS_SFP  = 3'd2,
    CLS_VFP  = 3'd3,
    CLS_QUAD = 3'd4
  } op_cls_e;

  // Per-slot capabilities after affinity and hazard screening
  typedef struct packed {
    logic to_vs1;
    logic to_vs2;
    logic is_fp;
    logic is_quad;
    logic arms_wb;
  } slot_caps_t;

endpackage

// File: rtl/vsarb_slot_decode.sv
module vsarb_slot_decode
  import vsarb_pkg::*;
#(
  parameter int N = NSLOT
) (
  input  logic [N-1:0]       vld_i,
  input  logic [N*CLS_W-1:0] cls_i,
  input  logic               wb_block_i,
  output slot_caps_t         caps_o [N]
);

  for (genvar k = 0; k < N; k++) begin : g_slot
    logic [CLS_W-1:0] cls_k;
    assign cls_k = cls_i[k*CLS_W +: CLS_W];

    always_comb begin
      caps_o[k] = '0;
      if (vld_i[k]) begin
        case (cls_k)
          CLS_XS:   caps_o[k].to_vs1 = !wb_block_i;
          CLS_PERM: caps_o[k].to_vs2 = 1'b1;
          CLS_SFP: begin
            caps_o[k].to_vs1 = 1'b1;
            caps_o[k].to_vs2 = 1'b1;
            caps_o[k].is_fp  = 1'b1;
          end
          CLS_VFP: begin
            caps_o[k].to_vs1  = 1'b1;
            caps_o[k].to_vs2  = 1'b1;
            caps_o[k].is_fp   = 1'b1;
            caps_o[k].arms_wb = 1'b1;
          end
          CLS_QUAD: begin
            caps_o[k].to_vs1  = 1'b1;
            caps_o[k].to_vs2  = 1'b1;
            caps_o[k].is_fp   = 1'b1;
            caps_o[k].is_quad = 1'b1;
            caps_o[k].arms_wb = 1'b1;
          end
          default: caps_o[k] = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/vsarb_wb_history.sv
module vsarb_wb_history #(
  parameter int GAP = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  output logic block_o
);

  logic [GAP-1:0] hist_q, hist_d;
  logic           hist_en;

  // bit i set: VS1 vector FP issue i+1 cycles ago
  always_comb begin
    hist_d  = {hist_q[GAP-2:0], arm_i};
    hist_en = arm_i | (|hist_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hist_q <= '0;
    else if (hist_en) hist_q <= hist_d;
  end

  assign block_o = hist_q[GAP-1];

endmodule

// File: rtl/vsarb_pair_select.sv
module vsarb_pair_select
  import vsarb_pkg::*;
(
  input  slot_caps_t  caps_i [NSLOT],
  output logic [NSLOT-1:0] gnt_o,
  output logic [NSLOT-1:0] pipe_o
);

  logic pair_direct, pair_swap;

  always_comb begin
    // older on VS1, younger on VS2
    pair_direct = caps_i[0].to_vs1 && caps_i[1].to_vs2 &&
                  !(caps_i[0].is_quad && caps_i[1].is_fp);
    // older on VS2, younger on VS1
    pair_swap   = caps_i[0].to_vs2 && caps_i[1].to_vs1 &&
                  !(caps_i[1].is_quad && caps_i[0].is_fp);

    gnt_o  = '0;
    pipe_o = '0;
    if (pair_direct) begin
      gnt_o  = 2'b11;
      pipe_o = 2'b10;
    end else if (pair_swap) begin
      gnt_o  = 2'b11;
      pipe_o = 2'b01;
    end else if (caps_i[0].to_vs1) begin
      gnt_o  = 2'b01;
    end else if (caps_i[0].to_vs2) begin
      gnt_o  = 2'b01;
      pipe_o = 2'b01;
    end else if (caps_i[1].to_vs1) begin
      gnt_o  = 2'b10;
    end else if (caps_i[1].to_vs2) begin
      gnt_o  = 2'b10;
      pipe_o = 2'b10;
    end
  end

endmodule

// File: rtl/vs_issue_arb.sv
module vs_issue_arb
  import vsarb_pkg::*;
#(
  parameter int WB_GAP = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSLOT-1:0]       req_vld_i,
  input  logic [NSLOT*CLS_W-1:0] req_cls_i,
  output logic [NSLOT-1:0]       gnt_o,
  output logic [NSLOT-1:0]       gnt_pipe_o,
  output logic [NSLOT-1:0]       stall_o
);

  logic [SYNC_DEPTH-1:0] rst_sync_q;
  logic                  rst_sync_n;
  slot_caps_t            caps [NSLOT];
  logic                  wb_block;
  logic [NSLOT-1:0]      arm_slot;
  logic                  wb_arm;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_DEPTH-2:0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[SYNC_DEPTH-1];

  vsarb_slot_decode #(.N(NSLOT)) i_decode (
    .vld_i      (req_vld_i),
    .cls_i      (req_cls_i),
    .wb_block_i (wb_block),
    .caps_o     (caps)
  );

  vsarb_pair_select i_select (
    .caps_i (caps),
    .gnt_o  (gnt_o),
    .pipe_o (gnt_pipe_o)
  );

  for (genvar k = 0; k < NSLOT; k++) begin : g_arm
    assign arm_slot[k] = gnt_o[k] && !gnt_pipe_o[k] && caps[k].arms_wb;
  end
  assign wb_arm = |arm_slot;

  vsarb_wb_history #(.GAP(WB_GAP)) i_history (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .arm_i   (wb_arm),
    .block_o (wb_block)
  );

  assign stall_o = req_vld_i & ~gnt_o;

endmodule

// File: rtl/vsarb_checker.sv
module vsarb_checker #(
  parameter int WB_GAP = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] req_vld_i,
  input logic [5:0] req_cls_i,
  input logic [1:0] gnt_o,
  input logic [1:0] gnt_pipe_o,
  input logic [1:0] stall_o
);

  function automatic logic cls_is_fp(input logic [2:0] c);
    return (c == 3'd2) || (c == 3'd3) || (c == 3'd4);
  endfunction

  logic [WB_GAP-1:0] ref_hist;
  logic [1:0]        arm_seen;

  for (genvar k = 0; k < 2; k++) begin : g_arm
    assign arm_seen[k] = gnt_o[k] && !gnt_pipe_o[k] &&
                         ((req_cls_i[3*k +: 3] == 3'd3) || (req_cls_i[3*k +: 3] == 3'd4));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_hist <= '0;
    else        ref_hist <= {ref_hist[WB_GAP-2:0], |arm_seen};
  end

  for (genvar k = 0; k < 2; k++) begin : g_slot
    assert_xs_vs1_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o[k] && req_cls_i[3*k +: 3] == 3'd0) |-> !gnt_pipe_o[k]);

    assert_perm_vs2_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o[k] && req_cls_i[3*k +: 3] == 3'd1) |-> gnt_pipe_o[k]);

    assert_quad_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o[k] && !gnt_pipe_o[k] && req_cls_i[3*k +: 3] == 3'd4 && gnt_o[1-k])
        |-> !cls_is_fp(req_cls_i[3*(1-k) +: 3]));

    assert_wb_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o[k] && !gnt_pipe_o[k] && req_cls_i[3*k +: 3] == 3'd0) |-> !ref_hist[WB_GAP-1]);

    assert_bad_cls_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_cls_i[3*k +: 3] > 3'd4) |-> !gnt_o[k]);
  end

  assert_one_per_pipe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (&gnt_o) |-> (gnt_pipe_o[0] != gnt_pipe_o[1]));

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o == (req_vld_i & ~gnt_o)) && ((gnt_o & ~req_vld_i) == 2'b00)
      && ((gnt_pipe_o & ~gnt_o) == 2'b00));

endmodule

bind vs_issue_arb vsarb_checker #(.WB_GAP(WB_GAP)) i_vsarb_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_vld_i  (req_vld_i),
  .req_cls_i  (req_cls_i),
  .gnt_o      (gnt_o),
  .gnt_pipe_o (gnt_pipe_o),
  .stall_o    (stall_o)
);

// File: tb/test_vs_issue_arb.sv
module test_vs_issue_arb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  localparam logic [2:0] XS = 3'd0, PERM = 3'd1, SFP = 3'd2, VFP = 3'd3, QUAD = 3'd4;

  logic       clk;
  logic       rst_n;
  logic [1:0] req_vld;
  logic [5:0] req_cls;
  logic [1:0] gnt, pipe, stall;

  int n_chk  = 0;
  int n_fail = 0;

  vs_issue_arb i_vs_issue_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_vld_i  (req_vld),
    .req_cls_i  (req_cls),
    .gnt_o      (gnt),
    .gnt_pipe_o (pipe),
    .stall_o    (stall)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input logic [1:0] v, input logic [2:0] c0, input logic [2:0] c1);
    @(negedge clk);
    req_vld = v;
    req_cls = {c1, c0};
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(2'b00, XS, XS);
  endtask

  task automatic expect_out(input string tag, input logic [1:0] eg,
                            input logic [1:0] ep, input logic [1:0] es);
    n_chk++;
    if (gnt !== eg || pipe !== ep || stall !== es) begin
      n_fail++;
      $display("FAIL %s: got gnt=%b pipe=%b stall=%b expected gnt=%b pipe=%b stall=%b",
               tag, gnt, pipe, stall, eg, ep, es);
    end
  endtask

  task automatic t_reset_state;
    idle(1);
    expect_out("R10 idle after reset", 2'b00, 2'b00, 2'b00);
    step(2'b00, 3'd7, 3'd5);
    expect_out("R8 invalid slots ignored", 2'b00, 2'b00, 2'b00);
  endtask

  task automatic t_affinity;
    step(2'b01, XS, XS);
    expect_out("R1 lone XS on VS1", 2'b01, 2'b00, 2'b00);
    step(2'b01, PERM, XS);
    expect_out("R2 lone PERM on VS2", 2'b01, 2'b01, 2'b00);
    step(2'b01, SFP, XS);
    expect_out("R3 lone SFP on VS1", 2'b01, 2'b00, 2'b00);
    step(2'b10, XS, SFP);
    expect_out("R3 younger SFP alone on VS1", 2'b10, 2'b00, 2'b00);
  endtask

  task automatic t_pairing;
    step(2'b11, SFP, SFP);
    expect_out("R4 two SFP older VS1", 2'b11, 2'b10, 2'b00);
    step(2'b11, SFP, XS);
    expect_out("R4 swapped pairing SFP+XS", 2'b11, 2'b01, 2'b00);
    step(2'b11, PERM, SFP);
    expect_out("R4 swapped pairing PERM+SFP", 2'b11, 2'b01, 2'b00);
    step(2'b11, XS, XS);
    expect_out("R7 two XS older wins", 2'b01, 2'b00, 2'b10);
    step(2'b11, PERM, PERM);
    expect_out("R7 two PERM older wins", 2'b01, 2'b01, 2'b10);
  endtask

  task automatic t_quad;
    step(2'b11, QUAD, QUAD);
    expect_out("R5 two QUAD one issues", 2'b01, 2'b00, 2'b10);
    idle(6);
    step(2'b11, QUAD, PERM);
    expect_out("R5 QUAD VS1 with PERM VS2", 2'b11, 2'b10, 2'b00);
    idle(6);
    step(2'b11, QUAD, SFP);
    expect_out("R5 QUAD moves to VS2 beside SFP", 2'b11, 2'b01, 2'b00);
    idle(6);
  endtask

  task automatic t_wb_window;
    step(2'b01, VFP, XS);
    expect_out("R6 arm VFP on VS1", 2'b01, 2'b00, 2'b00);
    idle(3);
    step(2'b01, XS, XS);
    expect_out("R6 XS at distance 4", 2'b01, 2'b00, 2'b00);
    step(2'b11, XS, PERM);
    expect_out("R6 XS blocked at distance 5, R7 PERM goes", 2'b10, 2'b10, 2'b01);
    step(2'b01, XS, XS);
    expect_out("R6 XS at distance 6", 2'b01, 2'b00, 2'b00);
    idle(6);
    step(2'b01, QUAD, XS);
    expect_out("R6 arm QUAD on VS1", 2'b01, 2'b00, 2'b00);
    idle(4);
    step(2'b11, XS, VFP);
    expect_out("R7 blocked XS, younger VFP takes VS1", 2'b10, 2'b00, 2'b01);
    idle(6);
  endtask

  task automatic t_no_arm;
    step(2'b01, SFP, XS);
    expect_out("R6 SFP on VS1", 2'b01, 2'b00, 2'b00);
    idle(4);
    step(2'b01, XS, XS);
    expect_out("R6 SFP does not arm", 2'b01, 2'b00, 2'b00);
    idle(6);
    step(2'b11, XS, VFP);
    expect_out("R6 XS VS1 with VFP VS2", 2'b11, 2'b10, 2'b00);
    idle(4);
    step(2'b01, XS, XS);
    expect_out("R6 VFP on VS2 does not arm", 2'b01, 2'b00, 2'b00);
    idle(6);
  endtask

  task automatic t_bad_class;
    step(2'b01, 3'd5, XS);
    expect_out("R9 code 5 stalled", 2'b00, 2'b00, 2'b01);
    step(2'b11, 3'd7, SFP);
    expect_out("R9 code 7 stalled, younger issues", 2'b10, 2'b00, 2'b01);
  endtask

  task automatic t_reset_clears;
    step(2'b01, VFP, XS);
    expect_out("R10 arm before reset", 2'b01, 2'b00, 2'b00);
    @(negedge clk);
    rst_n   = 1'b0;
    req_vld = 2'b00;
    #1;
    expect_out("R10 outputs idle in reset", 2'b00, 2'b00, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    step(2'b01, XS, XS);
    expect_out("R10 history cleared by reset", 2'b01, 2'b00, 2'b00);
    idle(4);
  endtask

  initial begin
    rst_n   = 1'b0;
    req_vld = 2'b00;
    req_cls = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state;
    t_affinity;
    t_pairing;
    t_quad;
    t_wb_window;
    t_no_arm;
    t_bad_class;
    t_reset_clears;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got no completion expected end within %0d cycles", WATCHDOG);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule